// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block models the control side of a byte-wide parallel flash device, backed by an on-chip byte array. A host drives active-low chip-enable, output-enable and write-enable strobes, an address bus and a data bus. The data bus is split into an input, an output and an output-enable for on-chip use. All strobes are sampled by a system clock. Plain reads return stored bytes. Changes to the array happen only through unlock command sequences: one sequence programs a single byte, and another erases the whole array.

Program and erase run for a fixed number of clock cycles, counted inside the block. While one runs, reads return a status byte that the host polls until the real data comes back. The lowest eighth of the array is a boot region. When the lock input is high, erase skips the boot region and programming into it is refused. The address width is a parameter, and the unlock addresses are the low address bits of 5555h and 2AAAh. With a 16-bit address the array is 64K bytes and the boot region is 0000h–1FFFh.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: `dq_oe` is 1 only when the previous clock sampled `ce_n`=0, `oe_n`=0 and `we_n`=1; with either of `ce_n` or `oe_n` high it is 0.
- R2: When no operation is running, a read returns the stored byte at the sampled address.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h followed by data D at address A start a program; once it finishes, the byte at A becomes its old value AND D.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h start a chip erase, which leaves every byte FFh when the lock is low.
- R5: A write that does not match the next expected step of a sequence returns the decoder to idle, so the writes that follow do not complete the aborted sequence.
- R6: A program keeps the block busy for PROG_CYCLES clocks. During that time a read returns a status byte: bit 7 is the complement of bit 7 of D and bits 6:0 are 0. After it finishes, the read returns the true byte.
- R7: An erase keeps the block busy for 2^ADDR_W + ERASE_EXTRA clocks, and during that time a read returns 00h.
- R8: Writes made while the block is busy are ignored; they do not advance any command sequence.
- R9: When `boot_lock` is 1 at the start, erase leaves addresses below 2^ADDR_W/8 unchanged, and a program aimed there is dropped without becoming busy.
- R10: A write cycle takes its address when CE and WE are first both low (the later of the two falling edges), and takes its data as last seen before the first of the two strobes rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data bus, host to device |
| dq_o | output | 8 | Data bus, device to host (array byte or status) |
| dq_oe | output | 1 | Enable for driving `dq_o` onto the shared bus |
| boot_lock | input | 1 | Enables protection of the boot region |

## Verification
The bench builds the block with ADDR_W=10, PROG_CYCLES=40 and ERASE_EXTRA=30. That gives a 1K-byte array with a 128-byte boot region, unlock addresses 155h and 2AAh, and a full erase sweep of about a thousand cycles, so several erases fit in one run. The program time of 40 cycles is long enough that two complete bus writes, plus a status poll, fit inside one busy window. This lets the bench show that writes made while busy cannot prime a later sequence. A split-strobe write, in which WE falls before CE and the data changes after WE rises, shows which address and which data a cycle keeps.

// File: rtl/flash_pkg.sv
// Shared types and command constants for the flash command sequencer.
// Assumes commands are decoded on the low address bits only.
package flash_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_UNLK1,
        CS_UNLK2,
        CS_PROG_DATA,
        CS_ERS1,
        CS_ERS2,
        CS_ERS3
    } cmd_state_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_PROG,
        OP_ERASE
    } op_state_t;

    localparam logic [7:0]  KEY_FIRST   = 8'hAA;
    localparam logic [7:0]  KEY_SECOND  = 8'h55;
    localparam logic [7:0]  CMD_PROGRAM = 8'hA0;
    localparam logic [7:0]  CMD_ERASE   = 8'h80;
    localparam logic [7:0]  CMD_CHIP    = 8'h10;
    localparam logic [15:0] KEY_ADDR_A  = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B  = 16'h2AAA;

endpackage

// File: rtl/flash_bus_sampler.sv
// Samples the asynchronous host strobes with the system clock and turns
// each CE/WE low window into one write event. The address is taken when
// both strobes are first low. The data is the last value sampled while
// both are low. Assumes each strobe phase lasts at least two clocks.
module flash_bus_sampler #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic              ce_q, oe_q, we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        dq_q;
    logic              act, act_d;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        cap_data;

    assign act = ~ce_q & ~we_q;

    // Register the pins and capture the address and data of each write window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q     <= 1'b1;
            oe_q     <= 1'b1;
            we_q     <= 1'b1;
            addr_q   <= '0;
            dq_q     <= '0;
            act_d    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
            wr_valid <= 1'b0;
        end else begin
            ce_q     <= ce_n;
            oe_q     <= oe_n;
            we_q     <= we_n;
            addr_q   <= addr;
            dq_q     <= dq_i;
            act_d    <= act;
            if (act && !act_d) cap_addr <= addr_q;
            if (act)           cap_data <= dq_q;
            wr_valid <= !act && act_d;
        end
    end

    assign rd_en   = ~ce_q & ~oe_q & we_q;
    assign rd_addr = addr_q;
    assign wr_addr = cap_addr;
    assign wr_data = cap_data;

    p_single_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

// File: rtl/flash_cmd_decoder.sv
// Walks the unlock command sequences and issues one-cycle start pulses
// for byte program and chip erase. Any mismatching write returns it to idle.
// Assumes the engine reports busy from the cycle after a start.
module flash_cmd_decoder
    import flash_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output logic              start_prog,
    output logic              start_erase,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data
);

    localparam logic [ADDR_W-1:0] ADR_A = KEY_ADDR_A[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ADR_B = KEY_ADDR_B[ADDR_W-1:0];

    cmd_state_t state;
    logic       hit, is_k1, is_k2;

    assign hit   = wr_valid && !busy;
    assign is_k1 = (wr_addr == ADR_A) && (wr_data == KEY_FIRST);
    assign is_k2 = (wr_addr == ADR_B) && (wr_data == KEY_SECOND);

    // Advance the sequence on each accepted write and emit start pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= CS_IDLE;
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            tgt_addr    <= '0;
            tgt_data    <= '0;
        end else begin
            start_prog  <= 1'b0;
            start_erase <= 1'b0;
            if (hit) begin
                state <= CS_IDLE;
                unique case (state)
                    CS_IDLE:  if (is_k1) state <= CS_UNLK1;
                    CS_UNLK1: if (is_k2) state <= CS_UNLK2;
                    CS_UNLK2: begin
                        if (wr_addr == ADR_A && wr_data == CMD_PROGRAM)
                            state <= CS_PROG_DATA;
                        else if (wr_addr == ADR_A && wr_data == CMD_ERASE)
                            state <= CS_ERS1;
                    end
                    CS_PROG_DATA: begin
                        start_prog <= 1'b1;
                        tgt_addr   <= wr_addr;
                        tgt_data   <= wr_data;
                    end
                    CS_ERS1: if (is_k1) state <= CS_ERS2;
                    CS_ERS2: if (is_k2) state <= CS_ERS3;
                    CS_ERS3: if (wr_addr == ADR_A && wr_data == CMD_CHIP)
                        start_erase <= 1'b1;
                    default: state <= CS_IDLE;
                endcase
            end
        end
    end

    p_one_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase}));
    p_erase_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |-> ($past(wr_valid) && $past(wr_data) == CMD_CHIP));
    p_idle_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog || start_erase) |-> !$past(busy));

endmodule

// File: rtl/flash_op_engine.sv
// Holds the byte array and runs the timed program and erase operations.
// Program writes old AND new after PROG_CYCLES clocks. Erase sweeps one
// byte per clock and then waits ERASE_EXTRA clocks. Reads during either
// operation return a status byte. Assumes the array itself is not reset.
module flash_op_engine
    import flash_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PROG_CYCLES = 16,
    parameter int ERASE_EXTRA = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_lock,
    input  logic              start_prog,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic [7:0]        rd_data
);

    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_BYTES = DEPTH / 8;
    localparam int ERASE_LEN  = DEPTH + ERASE_EXTRA;
    localparam int MAX_LEN    = (ERASE_LEN > PROG_CYCLES) ? ERASE_LEN : PROG_CYCLES;
    localparam int CW         = $clog2(MAX_LEN + 1);
    localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(BOOT_BYTES);

    logic [7:0]        mem [DEPTH];
    op_state_t         op;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] p_addr;
    logic [7:0]        p_data;
    logic              lock_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_idx;
    logic [7:0]        wr_byte;
    logic              in_sweep;

    assign busy     = (op != OP_IDLE);
    assign in_sweep = (cnt < CW'(DEPTH));

    // Select the array write for the current operation cycle.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = p_addr;
        wr_byte = mem[p_addr] & p_data;
        if (op == OP_PROG && cnt == '0) begin
            wr_en = 1'b1;
        end else if (op == OP_ERASE && in_sweep) begin
            wr_idx  = cnt[ADDR_W-1:0];
            wr_byte = 8'hFF;
            wr_en   = !(lock_q && cnt[ADDR_W-1:0] < BOOT_END);
        end
    end

    // Sequence the operation and count its busy time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op     <= OP_IDLE;
            cnt    <= '0;
            p_addr <= '0;
            p_data <= '0;
            lock_q <= 1'b0;
        end else begin
            unique case (op)
                OP_IDLE: begin
                    if (start_prog && !(boot_lock && tgt_addr < BOOT_END)) begin
                        op     <= OP_PROG;
                        cnt    <= CW'(PROG_CYCLES - 1);
                        p_addr <= tgt_addr;
                        p_data <= tgt_data;
                    end else if (start_erase) begin
                        op     <= OP_ERASE;
                        cnt    <= '0;
                        lock_q <= boot_lock;
                    end
                end
                OP_PROG: begin
                    if (cnt == '0) op <= OP_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                OP_ERASE: begin
                    if (cnt == CW'(ERASE_LEN - 1)) op <= OP_IDLE;
                    else                           cnt <= cnt + 1'b1;
                end
                default: op <= OP_IDLE;
            endcase
        end
    end

    // Commit the selected byte into the array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_byte;
    end

    // Return the stored byte, or the status byte while an operation runs.
    always_comb begin
        if (op == OP_PROG)       rd_data = {~p_data[7], 7'b0};
        else if (op == OP_ERASE) rd_data = 8'h00;
        else                     rd_data = mem[rd_addr];
    end

    p_boot_safe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_ERASE && wr_idx < BOOT_END) |-> !lock_q);
    p_prog_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op == OP_PROG) |-> ((wr_byte & ~mem[wr_idx]) == 8'h00));
    p_locked_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_prog && boot_lock && tgt_addr < BOOT_END && !busy) |=> !busy);

endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top level of the flash command sequencer: strobe sampler, command decoder
// and operation engine. Drives the data bus only for valid read strobes.
// Assumes ADDR_W is at most 16.
module flash_cmd_ctrl #(
    parameter int ADDR_W      = 12,
    parameter int PROG_CYCLES = 16,
    parameter int ERASE_EXTRA = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe,
    input  logic              boot_lock
);

    logic              rd_en, wr_valid, busy, start_prog, start_erase;
    logic [ADDR_W-1:0] rd_addr, wr_addr, tgt_addr;
    logic [7:0]        wr_data, tgt_data, rd_data;

    flash_bus_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_i(dq_i), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    flash_cmd_decoder #(.ADDR_W(ADDR_W)) u_decoder (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .start_prog(start_prog),
        .start_erase(start_erase), .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    flash_op_engine #(
        .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES), .ERASE_EXTRA(ERASE_EXTRA)
    ) u_engine (
        .clk(clk), .rst_n(rst_n), .boot_lock(boot_lock),
        .start_prog(start_prog), .start_erase(start_erase),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data), .rd_addr(rd_addr),
        .busy(busy), .rd_data(rd_data)
    );

    assign dq_oe = rd_en;
    assign dq_o  = rd_data;

    p_read_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> ($past(!ce_n) && $past(!oe_n) && $past(we_n)));

endmodule

// File: tb/flash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_bench;

    localparam int AW   = 10;
    localparam int PC   = 40;
    localparam int EX   = 30;
    localparam int DEP  = 1 << AW;
    localparam logic [AW-1:0] KA = AW'(16'h5555 & (DEP - 1));
    localparam logic [AW-1:0] KB = AW'(16'h2AAA & (DEP - 1));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_i = '0;
    logic [7:0]    dq_o;
    logic          dq_oe;
    logic          boot_lock = 1'b0;
    int            tests = 0, fails = 0;
    bit            done = 1'b0;
    logic [7:0]    rv;
    logic          roe;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .PROG_CYCLES(PC), .ERASE_EXTRA(EX)) u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .boot_lock(boot_lock)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        repeat (3) @(negedge clk);
        rv = dq_o; roe = dq_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0); wr(a, d);
    endtask

    task automatic erase_seq();
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h80);
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h10);
    endtask

    task automatic t_reset();
        chk("R1 idle after reset", {7'b0, dq_oe}, 8'h00);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 no drive with WE low", {7'b0, dq_oe}, 8'h00);
        we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 no drive with OE high", {7'b0, dq_oe}, 8'h00);
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_erase();
        erase_seq();
        rd(10'h200);
        chk("R7 erase status", rv, 8'h00);
        chk("R1 drive on read", {7'b0, roe}, 8'h01);
        repeat (DEP + EX + 10) @(negedge clk);
        rd(10'h010); chk("R4 boot erased unlocked", rv, 8'hFF);
        rd(10'h200); chk("R4 main erased", rv, 8'hFF);
        rd(10'h3FF); chk("R4 top erased", rv, 8'hFF);
    endtask

    task automatic t_program();
        prog(10'h300, 8'h3C);
        rd(10'h300); chk("R6 status bit7 inverted", rv, 8'h80);
        repeat (PC) @(negedge clk);
        rd(10'h300); chk("R3 programmed byte", rv, 8'h3C);
        prog(10'h300, 8'hF0);
        rd(10'h300); chk("R6 status for bit7 one", rv, 8'h00);
        repeat (PC) @(negedge clk);
        rd(10'h300); chk("R3 AND with old", rv, 8'h30);
        rd(10'h301); chk("R2 neighbour untouched", rv, 8'hFF);
    endtask

    task automatic t_abort();
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'h77); wr(10'h301, 8'h00);
        repeat (4) @(negedge clk);
        rd(10'h301); chk("R5 aborted sequence", rv, 8'hFF);
        wr(KA, 8'hAA); wr(KA, 8'h55); wr(KA, 8'hA0); wr(10'h301, 8'h00);
        rd(10'h301); chk("R5 wrong second key", rv, 8'hFF);
    endtask

    task automatic t_busy();
        prog(10'h302, 8'h0F);
        wr(KA, 8'hAA); wr(KB, 8'h55);
        rd(10'h302); chk("R6 still busy", rv, 8'h80);
        repeat (PC) @(negedge clk);
        wr(KA, 8'hA0); wr(10'h303, 8'h00);
        repeat (4) @(negedge clk);
        rd(10'h303); chk("R8 busy writes ignored", rv, 8'hFF);
        rd(10'h302); chk("R8 program completed", rv, 8'h0F);
    endtask

    task automatic t_edges();
        wr(KA, 8'hAA); wr(KB, 8'h55); wr(KA, 8'hA0);
        @(negedge clk);
        addr = 10'h305; dq_i = 8'h55; we_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = 10'h304; ce_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1;
        @(negedge clk);
        dq_i = 8'h00;
        repeat (2) @(negedge clk);
        ce_n = 1'b1;
        repeat (PC + 4) @(negedge clk);
        rd(10'h304); chk("R10 address at later fall, data at first rise", rv, 8'h55);
        rd(10'h305); chk("R10 early address not used", rv, 8'hFF);
    endtask

    task automatic t_lock();
        prog(10'h020, 8'h12);
        repeat (PC) @(negedge clk);
        rd(10'h020); chk("R3 boot byte programmed unlocked", rv, 8'h12);
        boot_lock = 1'b1;
        prog(10'h020, 8'h00);
        rd(10'h020); chk("R9 locked program not busy", rv, 8'h12);
        repeat (PC) @(negedge clk);
        rd(10'h020); chk("R9 locked program dropped", rv, 8'h12);
        erase_seq();
        repeat (DEP + EX + 10) @(negedge clk);
        rd(10'h020); chk("R9 boot kept by erase", rv, 8'h12);
        rd(10'h304); chk("R9 main erased under lock", rv, 8'hFF);
        boot_lock = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_erase();
        t_program();
        t_abort();
        t_busy();
        t_edges();
        t_lock();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule